// File: doc/BRIEF.md
# Nested Reset Domain Controller

This block turns a handful of reset sources into four synchronised, active-low reset outputs, one for each of four nested domains: the debug domain, the system domain (peripherals), the core domain (processor core, interrupt controller and protection unit) and the test-access-port domain. Every output drops asynchronously the moment one of its sources asks for it. It rises again only through a synchroniser chain on the clock, so each domain leaves reset on a clean edge.

The sources are an asynchronous power-on reset, a test-port reset, and two single-cycle request pulses raised by a control register: a system request and a core-only request. Power-on reset hits every domain. A system request resets the peripherals and the core domain but leaves debug alone, so a debugger keeps its state across a software-triggered restart. A core request resets only the core domain. The test-port reset touches only the test-port domain.

Each request pulse is lengthened by a small state machine per request. Its states are `ST_IDLE` and `ST_HOLD`. Its transitions are: arm (`ST_IDLE` to `ST_HOLD` on a sampled request, loading a countdown of `MIN_CYC-1`), retrigger (`ST_HOLD` to `ST_HOLD` on a further request, reloading the countdown), count (`ST_HOLD` to `ST_HOLD` while the countdown is non-zero, decrementing it) and done (`ST_HOLD` to `ST_IDLE` when the countdown reads zero). Both machines are held in `ST_IDLE` while the debug output is asserted. This means requests arriving during power-on reset, or before the debug domain is released, are dropped.

Top module: `rst_domain_ctrl`

## Requirements
- R1: While `por_n` is low, all four outputs are low; a falling `por_n` drives them low without waiting for a clock edge.
- R2: After `por_n` rises between edges, all four outputs stay low at the first following rising edge and go high at the second one (SYNC_STAGES=2).
- R3: `dbg_rst_n` is driven low only by `por_n`; neither request ever asserts it.
- R4: A `sys_req` sampled high at rising edge k drives `sys_rst_n` and `core_rst_n` low right after edge k. They stay low through edge k+MIN_CYC+1 and rise at edge k+MIN_CYC+2, so each is held low for at least MIN_CYC cycles.
- R5: A `core_req` sampled high at edge k gives `core_rst_n` the same low window as R4; `sys_rst_n`, `dbg_rst_n` and `tap_rst_n` stay high.
- R6: A second request of the same kind that arrives before its domain is released extends the low window: the output rises at edge e+MIN_CYC+2, where e is the edge of the latest request.
- R7: When both requests are present, in the same cycle or in overlapping windows, `core_rst_n` is low over the union of both windows, and `core_rst_n` is low whenever `sys_rst_n` is low.
- R8: A request sampled at an edge where `dbg_rst_n` was low, including during power-on reset, is ignored and is not remembered afterwards.
- R9: A low on `trst_n` asserts only `tap_rst_n`, asynchronously. After `trst_n` rises between edges, `tap_rst_n` goes high at the second rising edge.
- R10: `por_n` low also asserts `tap_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for release synchronisation and pulse stretching |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| trst_n | input | 1 | Asynchronous test-port reset, active low |
| sys_req | input | 1 | System reset request pulse, active high |
| core_req | input | 1 | Core-only reset request pulse, active high |
| dbg_rst_n | output | 1 | Debug domain reset, active low |
| sys_rst_n | output | 1 | Peripheral/system domain reset, active low |
| core_rst_n | output | 1 | Core, interrupt controller and protection unit reset, active low |
| tap_rst_n | output | 1 | Test-access-port domain reset, active low |

## Verification
Two things can land in the same cycle: a system request and a core request, or a new request and a request that is still being stretched. The bench places a first request and then a second one of either kind at every offset from zero to eight cycles. Offset zero puts both in one cycle, and the larger offsets cover retrigger, back-to-back and disjoint windows. At every sample, each output is judged against the union of the low windows, computed arithmetically from the request edges and MIN_CYC. This confirms that `dbg_rst_n` and `tap_rst_n` never move.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } stretch_state_t;

    localparam int DOM_DBG  = 0;
    localparam int DOM_SYS  = 1;
    localparam int DOM_CORE = 2;
    localparam int DOM_TAP  = 3;
    localparam int NUM_DOM  = 4;

endpackage

// File: rtl/rdc_sync.sv
module rdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] shift_q;

    // Assert at once, release by shifting ones through the chain.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) shift_q <= '0;
        else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end

    assign rst_n = shift_q[STAGES-1];
endmodule

// File: rtl/rdc_stretch.sv
module rdc_stretch
    import rdc_pkg::*;
#(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active
);
    localparam int CW = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(MIN_CYC - 1);

    stretch_state_t state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic: arm, retrigger, count, done
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_d = ST_HOLD;
                    cnt_d   = LOAD;
                end
            end
            ST_HOLD: begin
                if (req) begin
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        active = (state_q == ST_HOLD);
    end
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
    import rdc_pkg::*;
#(
    parameter int MIN_CYC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic trst_n,
    input  logic sys_req,
    input  logic core_req,
    output logic dbg_rst_n,
    output logic sys_rst_n,
    output logic core_rst_n,
    output logic tap_rst_n
);
    logic               sys_act;
    logic               core_act;
    logic [NUM_DOM-1:0] dom_arst_n;
    logic [NUM_DOM-1:0] dom_rst_n;

    // Source-to-domain mapping (nested: debug outermost)
    always_comb begin
        dom_arst_n[DOM_DBG]  = por_n;
        dom_arst_n[DOM_SYS]  = por_n & ~sys_act;
        dom_arst_n[DOM_CORE] = por_n & ~sys_act & ~core_act;
        dom_arst_n[DOM_TAP]  = por_n & trst_n;
    end

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_sync
        rdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .arst_n (dom_arst_n[g]),
            .rst_n  (dom_rst_n[g])
        );
    end

    // Request stretchers live in the debug domain
    rdc_stretch #(.MIN_CYC(MIN_CYC)) u_sys_str (
        .clk    (clk),
        .rst_n  (dom_rst_n[DOM_DBG]),
        .req    (sys_req),
        .active (sys_act)
    );

    rdc_stretch #(.MIN_CYC(MIN_CYC)) u_core_str (
        .clk    (clk),
        .rst_n  (dom_rst_n[DOM_DBG]),
        .req    (core_req),
        .active (core_act)
    );

    assign dbg_rst_n  = dom_rst_n[DOM_DBG];
    assign sys_rst_n  = dom_rst_n[DOM_SYS];
    assign core_rst_n = dom_rst_n[DOM_CORE];
    assign tap_rst_n  = dom_rst_n[DOM_TAP];
endmodule

// File: rtl/rst_domain_ctrl_chk.sv
module rst_domain_ctrl_chk #(
    parameter int MIN_CYC = 4
) (
    input logic clk,
    input logic por_n,
    input logic trst_n,
    input logic sys_req,
    input logic dbg_rst_n,
    input logic sys_rst_n,
    input logic core_rst_n,
    input logic tap_rst_n
);
    localparam int LW = $clog2(MIN_CYC + 4) + 1;
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 low_cnt <= '0;
        else if (core_rst_n)        low_cnt <= '0;
        else if (~&low_cnt)         low_cnt <= low_cnt + 1'b1;
    end

    // R3
    dbg_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$fell(dbg_rst_n));

    // R7
    nest_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |-> !core_rst_n);

    // R4
    sys_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst_n) |-> $past(sys_req));

    // R4
    min_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(core_rst_n) && $past(dbg_rst_n)) |-> (low_cnt >= LW'(MIN_CYC)));

    // R9
    tap_src_chk: assert property (@(posedge clk) disable iff (!por_n)
        $fell(tap_rst_n) |-> !trst_n);
endmodule

bind rst_domain_ctrl rst_domain_ctrl_chk #(.MIN_CYC(MIN_CYC)) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .trst_n     (trst_n),
    .sys_req    (sys_req),
    .dbg_rst_n  (dbg_rst_n),
    .sys_rst_n  (sys_rst_n),
    .core_rst_n (core_rst_n),
    .tap_rst_n  (tap_rst_n)
);

// File: tb/rst_domain_ctrl_bench.sv
module rst_domain_ctrl_bench;
    localparam int MIN = 4;
    localparam int WIN = 22;

    logic clk = 1'b0;
    logic por_n, trst_n, sys_req, core_req;
    logic dbg_rst_n, sys_rst_n, core_rst_n, tap_rst_n;
    int   n_vec = 0;
    int   n_bad = 0;

    always #10 clk = ~clk;

    rst_domain_ctrl #(.MIN_CYC(MIN), .SYNC_STAGES(2)) u_rst_domain_ctrl (
        .clk        (clk),
        .por_n      (por_n),
        .trst_n     (trst_n),
        .sys_req    (sys_req),
        .core_req   (core_req),
        .dbg_rst_n  (dbg_rst_n),
        .sys_rst_n  (sys_rst_n),
        .core_rst_n (core_rst_n),
        .tap_rst_n  (tap_rst_n)
    );

    task automatic chk(input string tag, input string sig, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag, input logic d, input logic s, input logic c, input logic t);
        chk(tag, "dbg_rst_n", dbg_rst_n, d);
        chk(tag, "sys_rst_n", sys_rst_n, s);
        chk(tag, "core_rst_n", core_rst_n, c);
        chk(tag, "tap_rst_n", tap_rst_n, t);
    endtask

    function automatic logic in_win(input int e, input int j);
        return (j >= e) && (j <= e + MIN + 1);
    endfunction

    // Power-on sequence with requests held high throughout (R2, R8)
    task automatic por_cycle();
        sys_req = 1'b1; core_req = 1'b1;
        repeat (2) @(negedge clk);
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", "tap_rst_n", tap_rst_n, 1'b0);
        por_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_all("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        chk_all("R2", 1'b1, 1'b1, 1'b1, 1'b1);
        sys_req = 1'b0; core_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk);
            chk_all("R8", 1'b1, 1'b1, 1'b1, 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        por_n = 1'b0; trst_n = 1'b1; sys_req = 1'b0; core_req = 1'b0;
        @(negedge clk);
        por_cycle();

        // Asynchronous re-entry into power-on reset (R1)
        por_n = 1'b0;
        #1;
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        por_cycle();

        // Test-port reset touches only its own domain (R9)
        trst_n = 1'b0;
        #1;
        chk_all("R9", 1'b1, 1'b1, 1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        chk_all("R9", 1'b1, 1'b1, 1'b1, 1'b0);
        trst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk_all("R9", 1'b1, 1'b1, 1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        chk_all("R9", 1'b1, 1'b1, 1'b1, 1'b1);

        // Sweep: first request kind a, second kind b (0 none,1 sys,2 core), offset d
        for (int a = 1; a <= 2; a++) begin
            for (int b = 0; b <= 2; b++) begin
                for (int d = 0; d <= 8; d++) begin
                    int t1, t2;
                    t1 = 2; t2 = 2 + d;
                    for (int j = 0; j < WIN; j++) begin
                        logic exp_s, exp_c;
                        string tag;
                        sys_req  = ((j == t1) && (a == 1)) || ((j == t2) && (b == 1));
                        core_req = ((j == t1) && (a == 2)) || ((j == t2) && (b == 2));
                        @(posedge clk);
                        @(negedge clk);
                        sys_req = 1'b0; core_req = 1'b0;
                        exp_s = 1'b1; exp_c = 1'b1;
                        if (a == 1 && in_win(t1, j)) begin exp_s = 1'b0; exp_c = 1'b0; end
                        if (a == 2 && in_win(t1, j)) exp_c = 1'b0;
                        if (b == 1 && in_win(t2, j)) begin exp_s = 1'b0; exp_c = 1'b0; end
                        if (b == 2 && in_win(t2, j)) exp_c = 1'b0;
                        if (b == 0)      tag = (a == 1) ? "R4" : "R5";
                        else if (a == b) tag = "R6";
                        else             tag = "R7";
                        chk("R3", "dbg_rst_n", dbg_rst_n, 1'b1);
                        chk(tag, "sys_rst_n", sys_rst_n, exp_s);
                        chk(tag, "core_rst_n", core_rst_n, exp_c);
                        chk(tag, "tap_rst_n", tap_rst_n, 1'b1);
                    end
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule